// File: doc/BRIEF.md
# Wait/Hold Clock Divider with Commit Handshake

This block derives a slower clock from a domain clock by counting input cycles in two phases. A high count sets how many input cycles the output stays high and a low count sets how many it stays low. Each phase lasts its count plus one cycle, so a full output period is the sum of both counts plus two. Separate phase counts let software pick any integer ratio from 2 up to twice the field range, and an uneven duty cycle is allowed.

Software writes a single configuration word that holds both counts, a bypass bit and a commit bit. Counts written on their own are only staged. Setting the commit bit asks the divider to adopt the staged counts. The divider does so only where a full low phase ends, and the commit bit reads back as 1 until that moment. The bypass bit routes the input clock straight to the output. A parameter narrows both count fields to three bits for domains that need a smaller range.

Top module: `cdiv_wait_hold`

## Requirements
- R1: After a synchronous reset the configuration word reads 0 (both counts 0, bypass off, commit clear), and the output divides by 2: one input cycle high, one low.
- R2: With active counts W (high) and H (low), the output is high for W+1 input cycles and low for H+1 input cycles, so the period is W+H+2 cycles.
- R3: Configuration word layout: high count in bits [19:16], low count in bits [23:20], bypass in bit 24, commit in bit 25. A read returns the stored counts, bypass and commit pending; every other bit reads 0. With 4-bit fields, counts 15/15 give the largest ratio of 32.
- R4: A write with bit 25 at 0 stores the new counts (they read back at once) but leaves the running division unchanged.
- R5: A write with bit 25 at 1 makes bit 25 read 1 from the next cycle on; it reads 0 again from the cycle in which the staged counts become active.
- R6: Staged counts are loaded only at the clock edge that ends a complete low phase; the phase in progress always finishes with the old counts, so no phase is ever cut short.
- R7: While bypass (bit 24) is 1, the output equals the input clock and the counts have no visible effect; clearing it returns the divided output.
- R8: With the narrow variant (COUNT_W = 3) only the low three bits of each count field are stored; the top bit of each field is dropped and reads 0, so 15/15 written becomes 7/7, a ratio of 16.
- R9: A commit request stays pending across later writes that carry bit 25 at 0, and the counts loaded are those staged at the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, sampled on the rising edge of clk |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word (staged counts, bypass, commit pending) |
| clk_out | output | 1 | Divided clock, or clk itself in bypass |

## Verification
A write lands on the rising edge after the strobe is driven, so its readback and the commit bit are due half a cycle later, at the next falling edge, where the bench samples them. The divided output changes only on rising edges and the bypass output follows the clock level, so the bench samples the output in the middle of each half-cycle and compares it with a behavioural model advanced on every rising edge. Phase lengths are measured by counting mid-high samples from a rising output edge, which skips any phase already under way when a commit was issued.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int REG_W    = 32;
    localparam int FIELD_W  = 4;
    localparam int WAIT_LSB = 16;
    localparam int HOLD_LSB = 20;
    localparam int BYP_BIT  = 24;
    localparam int UPD_BIT  = 25;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hold_c;
        logic [FIELD_W-1:0] wait_c;
    } counts_t;

    function automatic logic [FIELD_W-1:0] field_mask(input int cnt_w);
        logic [FIELD_W-1:0] m;
        m = '0;
        for (int i = 0; i < FIELD_W; i++) begin
            if (i < cnt_w) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input counts_t c,
                                                  input logic byp,
                                                  input logic pend);
        logic [REG_W-1:0] r;
        r = '0;
        r[WAIT_LSB +: FIELD_W] = c.wait_c;
        r[HOLD_LSB +: FIELD_W] = c.hold_c;
        r[BYP_BIT]             = byp;
        r[UPD_BIT]             = pend;
        return r;
    endfunction

endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg
    import cdiv_pkg::*;
#(
    parameter int COUNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             apply_i,
    output counts_t          staged_o,
    output logic             bypass_o,
    output logic             pend_o,
    output logic [REG_W-1:0] rdata_o
);

    localparam logic [FIELD_W-1:0] CMASK = field_mask(COUNT_W);

    counts_t wr_counts;
    counts_t staged_q;
    logic    bypass_q;
    logic    pend_q;
    logic    unused_bits;

    assign unused_bits = ^{wdata[REG_W-1:UPD_BIT+1], wdata[WAIT_LSB-1:0]};

    generate
        if (COUNT_W >= FIELD_W) begin : g_full
            assign wr_counts.wait_c = wdata[WAIT_LSB +: FIELD_W];
            assign wr_counts.hold_c = wdata[HOLD_LSB +: FIELD_W];
        end else begin : g_narrow
            assign wr_counts.wait_c = wdata[WAIT_LSB +: FIELD_W] & CMASK;
            assign wr_counts.hold_c = wdata[HOLD_LSB +: FIELD_W] & CMASK;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            bypass_q <= 1'b0;
        end else if (we) begin
            staged_q <= wr_counts;
            bypass_q <= wdata[BYP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (we && wdata[UPD_BIT]) begin
            pend_q <= 1'b1;
        end else if (apply_i) begin
            pend_q <= 1'b0;
        end
    end

    assign staged_o = staged_q;
    assign bypass_o = bypass_q;
    assign pend_o   = pend_q;
    assign rdata_o  = pack_cfg(staged_q, bypass_q, pend_q);

    // R5: a commit write is visible as pending on the next cycle
    p_pend_set_r5: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[UPD_BIT]) |=> pend_q);

    // R5: pending only drops when the phase generator reported a load
    p_pend_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(apply_i));

endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen
    import cdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  counts_t staged_i,
    input  logic    pend_i,
    output logic    div_o,
    output logic    apply_o
);

    phase_e             phase_q;
    logic [FIELD_W-1:0] cnt_q;
    counts_t            act_q;
    logic               hi_done;
    logic               lo_done;

    assign hi_done = (phase_q == PH_HIGH) && (cnt_q == act_q.wait_c);
    assign lo_done = (phase_q == PH_LOW)  && (cnt_q == act_q.hold_c);
    assign apply_o = lo_done && pend_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
        end else if (hi_done) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else if (lo_done) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (apply_o) begin
            act_q <= staged_i;
        end
    end

    assign div_o = (phase_q == PH_HIGH);

    // R2: the high-phase counter never runs past the active high count
    p_hi_range_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH) |-> (cnt_q <= act_q.wait_c));

    // R2: the low-phase counter never runs past the active low count
    p_lo_range_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> (cnt_q <= act_q.hold_c));

    // R6: active counts stay put except at a committed end of low phase
    p_act_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !apply_o |=> $stable(act_q));

endmodule

// File: rtl/cdiv_out_mux.sv
module cdiv_out_mux (
    input  logic clk,
    input  logic bypass_i,
    input  logic div_i,
    output logic clk_o
);

    always_comb begin
        if (bypass_i) clk_o = clk;
        else          clk_o = div_i;
    end

endmodule

// File: rtl/cdiv_wait_hold.sv
module cdiv_wait_hold
    import cdiv_pkg::*;
#(
    parameter int COUNT_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        clk_out
);

    counts_t staged;
    logic    bypass;
    logic    pend;
    logic    apply;
    logic    div_q;

    cdiv_cfg_reg #(.COUNT_W(COUNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .apply_i  (apply),
        .staged_o (staged),
        .bypass_o (bypass),
        .pend_o   (pend),
        .rdata_o  (cfg_rdata)
    );

    cdiv_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .staged_i (staged),
        .pend_i   (pend),
        .div_o    (div_q),
        .apply_o  (apply)
    );

    cdiv_out_mux u_mux (
        .clk      (clk),
        .bypass_i (bypass),
        .div_i    (div_q),
        .clk_o    (clk_out)
    );

    // R1: reset leaves the configuration word cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cfg_rdata == '0));

endmodule

// File: tb/tb_cdiv_wait_hold.sv
module tb_ref_model #(
    parameter int CW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wd,
    output logic        exp_div,
    output logic        exp_byp,
    output logic [31:0] exp_rd
);
    int hi, cnt, aw, ah, sw, sh, byp, pend, lim;

    initial begin
        hi = 1; cnt = 0; aw = 0; ah = 0; sw = 0; sh = 0; byp = 0; pend = 0;
        exp_div = 1'b1; exp_byp = 1'b0; exp_rd = '0;
    end

    always @(posedge clk) begin
        lim = (1 << CW) - 1;
        if (rst) begin
            hi = 1; cnt = 0; aw = 0; ah = 0; sw = 0; sh = 0; byp = 0; pend = 0;
        end else begin
            if (hi == 1) begin
                if (cnt == aw) begin hi = 0; cnt = 0; end
                else cnt = cnt + 1;
            end else begin
                if (cnt == ah) begin
                    hi = 1; cnt = 0;
                    if (pend == 1) begin aw = sw; ah = sh; pend = 0; end
                end else cnt = cnt + 1;
            end
            if (we) begin
                sw = int'(wd[19:16]) & lim;
                sh = int'(wd[23:20]) & lim;
                byp = int'(wd[24]);
                if (wd[25]) pend = 1;
            end
        end
        exp_div = (hi == 1);
        exp_byp = (byp == 1);
        exp_rd = 32'(sw << 16) | 32'(sh << 20) | 32'(byp << 24) | 32'(pend << 25);
    end
endmodule

module tb_cdiv_wait_hold;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd_w, rd_n;
    logic        out_w, out_n;
    logic        m_div_w, m_byp_w, m_div_n, m_byp_n;
    logic [31:0] m_rd_w, m_rd_n;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    cdiv_wait_hold #(.COUNT_W(4)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_w), .clk_out(out_w));

    cdiv_wait_hold #(.COUNT_W(3)) dut_n (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_n), .clk_out(out_n));

    tb_ref_model #(.CW(4)) ref_w (
        .clk(clk), .rst(rst), .we(cfg_we), .wd(cfg_wdata),
        .exp_div(m_div_w), .exp_byp(m_byp_w), .exp_rd(m_rd_w));

    tb_ref_model #(.CW(3)) ref_n (
        .clk(clk), .rst(rst), .we(cfg_we), .wd(cfg_wdata),
        .exp_div(m_div_n), .exp_byp(m_byp_n), .exp_rd(m_rd_n));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_now();
        logic ew, en;
        ew = m_byp_w ? clk : m_div_w;
        en = m_byp_n ? clk : m_div_n;
        check(out_w === ew, cur_req, "wide clk_out", longint'(out_w), longint'(ew));
        check(out_n === en, "R8", "narrow clk_out", longint'(out_n), longint'(en));
        check(rd_w === m_rd_w, cur_req, "wide cfg_rdata", longint'(rd_w), longint'(m_rd_w));
        check(rd_n === m_rd_n, "R8", "narrow cfg_rdata", longint'(rd_n), longint'(m_rd_n));
    endtask

    initial begin
        forever begin
            @(posedge clk); #5;
            if (cmp_on) compare_now();
            @(negedge clk); #5;
            if (cmp_on) compare_now();
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    function automatic logic [31:0] cfgw(input int w, input int h, input bit byp, input bit upd);
        return 32'(w << 16) | 32'(h << 20) | 32'(int'(byp) << 24) | 32'(int'(upd) << 25);
    endfunction

    function automatic logic pick(input bit narrow);
        return narrow ? out_n : out_w;
    endfunction

    task automatic measure(input bit narrow, input int exp_hi, input int exp_lo, input string req);
        int hi_n, lo_n;
        logic s;
        hi_n = 0; lo_n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #5; s = pick(narrow);
            if (s == 1'b0) break;
        end
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #5; s = pick(narrow);
            if (s == 1'b1) break;
        end
        hi_n = 1;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #5; s = pick(narrow);
            if (s == 1'b1) hi_n++;
            else break;
        end
        lo_n = 1;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #5; s = pick(narrow);
            if (s == 1'b0) lo_n++;
            else break;
        end
        check(hi_n == exp_hi, req, "high phase length", longint'(hi_n), longint'(exp_hi));
        check(lo_n == exp_lo, req, "low phase length", longint'(lo_n), longint'(exp_lo));
    endtask

    task automatic wait_commit(input string req);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #5;
            if (rd_w[25] == 1'b0 && rd_n[25] == 1'b0) break;
        end
        check(rd_w[25] == 1'b0, req, "commit bit cleared", longint'(rd_w[25]), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #5;
        // R1: reset state
        check(rd_w == 32'h0, "R1", "cfg_rdata after reset", longint'(rd_w), 0);
        cmp_on = 1'b1;
        measure(1'b0, 1, 1, "R1");

        // R5 / R2: commit wait=2 hold=0
        cur_req = "R5";
        wr(cfgw(2, 0, 1'b0, 1'b1));
        #5;
        check(rd_w[25] == 1'b1, "R5", "commit bit pending", longint'(rd_w[25]), 1);
        wait_commit("R5");
        cur_req = "R2";
        measure(1'b0, 3, 1, "R2");

        // R6: commit issued mid high phase of a long setting
        wr(cfgw(1, 4, 1'b0, 1'b1));
        wait_commit("R6");
        measure(1'b0, 2, 5, "R2");
        cur_req = "R6";
        @(posedge clk); #5;
        wr(cfgw(6, 0, 1'b0, 1'b1));
        wait_commit("R6");
        measure(1'b0, 7, 1, "R6");

        // R4: staged only, division unchanged
        cur_req = "R4";
        wr(cfgw(7, 7, 1'b0, 1'b0));
        #5;
        check(rd_w == cfgw(7, 7, 1'b0, 1'b0), "R4", "staged counts readback",
              longint'(rd_w), longint'(cfgw(7, 7, 1'b0, 1'b0)));
        measure(1'b0, 7, 1, "R4");

        // R9: pending survives a later write without commit; latest counts load
        cur_req = "R9";
        wr(cfgw(5, 3, 1'b0, 1'b1));
        wr(cfgw(0, 6, 1'b0, 1'b0));
        #5;
        check(rd_w[25] == 1'b1 || rd_w[23:16] == 8'h60, "R9", "commit still pending or done",
              longint'(rd_w), longint'(cfgw(0, 6, 1'b0, 1'b1)));
        wait_commit("R9");
        measure(1'b0, 1, 7, "R9");

        // R3: layout, extra bits read 0, largest ratio 32
        cur_req = "R3";
        wr(32'hFC00_FFFF | cfgw(15, 15, 1'b0, 1'b1));
        #5;
        check(rd_w == cfgw(15, 15, 1'b0, 1'b1), "R3", "readback masks unused bits",
              longint'(rd_w), longint'(cfgw(15, 15, 1'b0, 1'b1)));
        check(rd_n == cfgw(7, 7, 1'b0, 1'b1), "R8", "narrow readback drops top bit",
              longint'(rd_n), longint'(cfgw(7, 7, 1'b0, 1'b1)));
        wait_commit("R3");
        measure(1'b0, 16, 16, "R3");
        // R8: narrow variant ratio 16
        measure(1'b1, 8, 8, "R8");

        // R7: bypass follows the input clock, counts ignored
        cur_req = "R7";
        wr(cfgw(3, 9, 1'b1, 1'b1));
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #5;
            check(out_w === 1'b1, "R7", "bypass high level", longint'(out_w), 1);
            @(negedge clk); #5;
            check(out_w === 1'b0, "R7", "bypass low level", longint'(out_w), 0);
        end
        wr(cfgw(3, 9, 1'b0, 1'b0));
        measure(1'b0, 4, 10, "R7");

        // R1: reset again mid-run
        cur_req = "R1";
        @(negedge clk);
        cmp_on = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #5;
        check(rd_w == 32'h0, "R1", "cfg_rdata after second reset", longint'(rd_w), 0);
        cmp_on = 1'b1;
        measure(1'b0, 1, 1, "R1");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule